// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block is a performance monitor that software drives through a plain 32-bit register bus with a one-cycle write strobe and a combinational read port. It holds a parameterised number of event counters. An optional free-running cycle counter sits in slot 31. Each event counter has an event-type register and a filter register. The event-type register chooses one of the `evt_in` lines. A counter advances on a clock in which the global enable is set, its own enable bit is set and its chosen line is high.

Three per-counter bit banks hold the counter enables, the interrupt enables and the overflow status. Each bank has a write-one-to-set address and a write-one-to-clear address, and both addresses read back the bank. When a counter rolls over from all ones to zero, its overflow bit is set. `irq` is high whenever some counter has both its overflow bit and its interrupt-enable bit set. A read-only configuration word describes the instance, so driver code can size itself from it.

Top module: `pmu_event_unit`

## Requirements
- R1: The word at 0xE00 is read-only. It holds bits [7:0] = number of counters including the cycle counter, minus one; bits [13:8] = counter width minus one; bit 14 = cycle counter present. For the default instance this is 0x00006704.
- R2: The word at 0xE08 returns the fixed IMPL_ID parameter value (default 0x0A5C1001).
- R3: Event counter i advances by one on a clock in which the global enable, enable bit i and the line `evt_in[type_i]` are all set. A type value of NUM_EVT or more never counts. When the global enable is clear, no counter moves.
- R4: The cycle counter uses slot 31. It advances on every clock in which the global enable and bit 31 of the enable bank are set.
- R5: Enable banks are at 0xC00 (set) and 0xC20 (clear). Interrupt-enable banks are at 0xC40 (set) and 0xC60 (clear). Counter i maps to bit i. Writing 0 bits has no effect. Both addresses of a pair read the current bank. Bits of slots that do not exist read 0.
- R6: Counters wider than 32 bits use an 8-byte stride, with the low word at 8*i and the high word at 8*i+4. The cycle counter's low word is at 0x0F8.
- R7: A counter that advances from all ones of its width wraps to zero and sets its overflow bit.
- R8: Writing ones to 0xC80 clears the matching overflow bits. Writing ones to 0xCC0 sets them. Both addresses read the overflow bank. A hardware wrap in the same cycle as a clear leaves the bit set.
- R9: `irq` is high exactly when some counter has both its overflow bit and its interrupt-enable bit set.
- R10: The control word is at 0xE04. Bit 0 is the global enable. Writing bit 1 as 1 zeroes every event counter, and writing bit 2 as 1 zeroes the cycle counter. A reset takes priority over a same-cycle increment. A read returns only bit 0.
- R11: A bus write to a counter word loads it. If an increment falls in the same cycle, the write wins.
- R12: The event-type words at 0x400+4*i keep their low TYPE_W bits (8 by default). The filter words at 0xA00+4*i and the cycle filter at 0x47C keep all 32 bits. All of them read back what was written.
- R13: After reset, every counter, bank, type, filter and control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_EVT | Event lines, each counted when high on a clock edge |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
On every cycle the assertions check the following:
- the configuration word reads its fixed value;
- the cycle counter holds still while the global enable is off and no write is made;
- a set write to the enable bank takes effect on the next cycle;
- an overflow clear takes effect on the next cycle while the unit is idle;
- clearing every interrupt enable drops `irq`;
- bits of absent slots stay zero.

Only the bench's scenarios can show the following:
- counting against the type selection and random events;
- the precise wrap cycle of a 40-bit counter loaded through its two words;
- write-versus-increment and reset-versus-increment priority;
- the control reset bits;
- the no-effect cases of zero writes.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets, control bit positions and the slot mask
// helper for the event counter unit. Assumes a 12-bit byte offset bus.
package pmu_pkg;
    localparam logic [11:0] OFF_CNTEN_SET = 12'hC00;
    localparam logic [11:0] OFF_CNTEN_CLR = 12'hC20;
    localparam logic [11:0] OFF_INTEN_SET = 12'hC40;
    localparam logic [11:0] OFF_INTEN_CLR = 12'hC60;
    localparam logic [11:0] OFF_OVF_CLR   = 12'hC80;
    localparam logic [11:0] OFF_OVF_SET   = 12'hCC0;
    localparam logic [11:0] OFF_CFG       = 12'hE00;
    localparam logic [11:0] OFF_CTRL      = 12'hE04;
    localparam logic [11:0] OFF_IDENT     = 12'hE08;
    localparam logic [4:0]  TYPE_PAGE     = 5'b01000;  // 0x400..0x47F
    localparam logic [4:0]  FILT_PAGE     = 5'b10100;  // 0xA00..0xA7F
    localparam int          CYC_SLOT      = 31;
    localparam int          CTRL_EN       = 0;
    localparam int          CTRL_RST_EVT  = 1;
    localparam int          CTRL_RST_CYC  = 2;

    // Bit mask of implemented counter slots.
    function automatic logic [31:0] slot_mask(input int n, input bit cyc);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++)
            if (i < n) m[i] = 1'b1;
        if (cyc) m[CYC_SLOT] = 1'b1;
        return m;
    endfunction

    // Read-only configuration word.
    function automatic logic [31:0] cfg_word(input int n, input int w, input bit cyc);
        return (32'(cyc) << 14) | (32'(w - 1) << 8) | 32'(n + int'(cyc) - 1);
    endfunction
endpackage

// File: rtl/pmu_ctr_core.sv
`timescale 1ns/1ps
// Counter core: a W-bit up-counter. The bus loads it one 32-bit word at a
// time. A clear has the highest priority, then a load, then an increment.
// wrap pulses when an increment rolls the counter over from all ones.
// Assumes 1 <= W <= 64.
module pmu_ctr_core #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [31:0]  wdata,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] loaded;

    // Merge the written word into the current value.
    always_comb begin
        loaded = cnt;
        for (int b = 0; b < W; b++)
            if (b < 32 ? wr_lo : wr_hi) loaded[b] = wdata[b % 32];
    end

    // Roll-over is only a real wrap when no clear or load overrides it.
    assign wrap = inc & ~clr & ~wr_lo & ~wr_hi & (&cnt);

    // Counter state with clear > load > increment priority.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (wr_lo || wr_hi)  cnt <= loaded;
        else if (inc)             cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pmu_ctr_slice.sv
`timescale 1ns/1ps
// Counter slice: one event counter with its event-type and filter words.
// The type value picks an event line. Values at or above NUM_EVT select
// nothing. The filter word is stored for software and read back unchanged.
// Assumes TYPE_W <= 32.
module pmu_ctr_slice #(
    parameter int W       = 40,
    parameter int TYPE_W  = 8,
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               run,
    input  logic               clr,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic               wr_type,
    input  logic               wr_filt,
    input  logic [31:0]        wdata,
    output logic [W-1:0]       cnt,
    output logic [31:0]        type_rd,
    output logic [31:0]        filt_rd,
    output logic               wrap
);
    logic [TYPE_W-1:0] type_q;
    logic [31:0]       filt_q;
    logic              evt_sel;

    // Event line chosen by the type word.
    always_comb begin
        evt_sel = 1'b0;
        for (int e = 0; e < NUM_EVT; e++)
            if (type_q == TYPE_W'(e)) evt_sel = evt_in[e];
    end

    // Type and filter storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            filt_q <= '0;
        end else begin
            if (wr_type) type_q <= wdata[TYPE_W-1:0];
            if (wr_filt) filt_q <= wdata;
        end
    end

    assign type_rd = 32'(type_q);
    assign filt_rd = filt_q;

    pmu_ctr_core #(.W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (wdata),
        .inc   (run & evt_sel),
        .cnt   (cnt),
        .wrap  (wrap)
    );
endmodule

// File: rtl/pmu_bit_bank.sv
`timescale 1ns/1ps
// Set/clear bit bank: 32 state bits. One strobe sets bits with write-one,
// another clears them, and a hardware vector sets them. Set wins over
// clear. Bits outside MASK are held at zero.
module pmu_bit_bank #(
    parameter logic [31:0] MASK = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] bits
);
    // Bank state update.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= ((bits & ~(clr_we ? wdata : 32'd0))
                             | (set_we ? wdata : 32'd0) | hw_set) & MASK;
    end
endmodule

// File: rtl/pmu_event_unit.sv
`timescale 1ns/1ps
// Event counter unit top: decodes the register bus, builds NUM_CTR counter
// slices plus an optional cycle counter in slot 31, three set/clear banks,
// the control flop and the read mux. Assumes NUM_CTR <= 31, CTR_W <= 64,
// and word-aligned accesses.
module pmu_event_unit
    import pmu_pkg::*;
#(
    parameter int          NUM_CTR = 4,
    parameter int          CTR_W   = 40,
    parameter bit          HAS_CYC = 1'b1,
    parameter int          NUM_EVT = 4,
    parameter int          TYPE_W  = 8,
    parameter logic [31:0] IMPL_ID = 32'h0A5C_1001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               reg_wr,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam bit          WIDE      = (CTR_W > 32);
    localparam logic [31:0] IMPL_MASK = slot_mask(NUM_CTR, HAS_CYC);
    localparam logic [31:0] CFG_WORD  = cfg_word(NUM_CTR, CTR_W, HAS_CYC);

    logic        glb_en;
    logic [31:0] cyc_filt_q;
    logic [31:0] cnten, inten, ovf, wrap_v;
    logic [63:0] ctr64  [32];
    logic [31:0] typ_rd [32];
    logic [31:0] flt_rd [32];
    logic [31:0] wr_lo_v, wr_hi_v, wr_type_v, wr_filt_v;
    logic [4:0]  c_idx, r_idx;
    logic        c_hit, c_hi, t_hit, f_hit;
    logic        ctrl_we, clr_evt, clr_cyc;
    logic [63:0] cyc_val64;

    // Address decode into per-slot one-hot write strobes.
    always_comb begin
        c_hit     = WIDE ? (reg_addr[11:8] == 4'd0) : (reg_addr[11:7] == 5'd0);
        c_idx     = WIDE ? reg_addr[7:3] : reg_addr[6:2];
        c_hi      = WIDE & reg_addr[2];
        r_idx     = reg_addr[6:2];
        t_hit     = (reg_addr[11:7] == TYPE_PAGE);
        f_hit     = (reg_addr[11:7] == FILT_PAGE);
        wr_lo_v   = (reg_wr && c_hit && !c_hi) ? (32'd1 << c_idx) : 32'd0;
        wr_hi_v   = (reg_wr && c_hit &&  c_hi) ? (32'd1 << c_idx) : 32'd0;
        wr_type_v = (reg_wr && t_hit) ? (32'd1 << r_idx) : 32'd0;
        wr_filt_v = (reg_wr && f_hit) ? (32'd1 << r_idx) : 32'd0;
        ctrl_we   = reg_wr && (reg_addr == OFF_CTRL);
        clr_evt   = ctrl_we && reg_wdata[CTRL_RST_EVT];
        clr_cyc   = ctrl_we && reg_wdata[CTRL_RST_CYC];
    end

    for (genvar k = 0; k < 32; k++) begin : g_slot
        if (k < NUM_CTR) begin : g_evt
            logic [CTR_W-1:0] cnt_k;
            logic             wrap_k;
            pmu_ctr_slice #(.W(CTR_W), .TYPE_W(TYPE_W), .NUM_EVT(NUM_EVT)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt_in  (evt_in),
                .run     (glb_en & cnten[k]),
                .clr     (clr_evt),
                .wr_lo   (wr_lo_v[k]),
                .wr_hi   (wr_hi_v[k]),
                .wr_type (wr_type_v[k]),
                .wr_filt (wr_filt_v[k]),
                .wdata   (reg_wdata),
                .cnt     (cnt_k),
                .type_rd (typ_rd[k]),
                .filt_rd (flt_rd[k]),
                .wrap    (wrap_k)
            );
            assign ctr64[k]  = 64'(cnt_k);
            assign wrap_v[k] = wrap_k;
        end else if (k == CYC_SLOT && HAS_CYC) begin : g_cyc
            logic [CTR_W-1:0] cnt_k;
            logic             wrap_k;
            pmu_ctr_core #(.W(CTR_W)) u_cyc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr_cyc),
                .wr_lo (wr_lo_v[k]),
                .wr_hi (wr_hi_v[k]),
                .wdata (reg_wdata),
                .inc   (glb_en & cnten[k]),
                .cnt   (cnt_k),
                .wrap  (wrap_k)
            );
            assign ctr64[k]  = 64'(cnt_k);
            assign wrap_v[k] = wrap_k;
            assign typ_rd[k] = cyc_filt_q;
            assign flt_rd[k] = 32'd0;
        end else begin : g_none
            assign ctr64[k]  = 64'd0;
            assign wrap_v[k] = 1'b0;
            assign typ_rd[k] = 32'd0;
            assign flt_rd[k] = 32'd0;
        end
    end

    assign cyc_val64 = ctr64[CYC_SLOT];

    // Global enable and cycle-counter filter word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en     <= 1'b0;
            cyc_filt_q <= '0;
        end else begin
            if (ctrl_we) glb_en <= reg_wdata[CTRL_EN];
            if (wr_type_v[CYC_SLOT] && HAS_CYC) cyc_filt_q <= reg_wdata;
        end
    end

    pmu_bit_bank #(.MASK(IMPL_MASK)) u_cnten (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == OFF_CNTEN_SET),
        .clr_we(reg_wr && reg_addr == OFF_CNTEN_CLR),
        .wdata(reg_wdata), .hw_set(32'd0), .bits(cnten)
    );
    pmu_bit_bank #(.MASK(IMPL_MASK)) u_inten (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == OFF_INTEN_SET),
        .clr_we(reg_wr && reg_addr == OFF_INTEN_CLR),
        .wdata(reg_wdata), .hw_set(32'd0), .bits(inten)
    );
    pmu_bit_bank #(.MASK(IMPL_MASK)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == OFF_OVF_SET),
        .clr_we(reg_wr && reg_addr == OFF_OVF_CLR),
        .wdata(reg_wdata), .hw_set(wrap_v), .bits(ovf)
    );

    assign irq = |(ovf & inten);

    // Combinational read mux.
    always_comb begin
        reg_rdata = 32'd0;
        if (c_hit)      reg_rdata = c_hi ? ctr64[c_idx][63:32] : ctr64[c_idx][31:0];
        else if (t_hit) reg_rdata = typ_rd[r_idx];
        else if (f_hit) reg_rdata = flt_rd[r_idx];
        else begin
            case (reg_addr)
                OFF_CNTEN_SET, OFF_CNTEN_CLR: reg_rdata = cnten;
                OFF_INTEN_SET, OFF_INTEN_CLR: reg_rdata = inten;
                OFF_OVF_CLR,   OFF_OVF_SET:   reg_rdata = ovf;
                OFF_CFG:                      reg_rdata = CFG_WORD;
                OFF_CTRL:                     reg_rdata = {31'd0, glb_en};
                OFF_IDENT:                    reg_rdata = IMPL_ID;
                default:                      reg_rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/pmu_event_unit_chk.sv
`timescale 1ns/1ps
// Checker for pmu_event_unit: properties over the register bus, the
// interrupt and the bank state. It is attached by the bind at the bottom
// of this file.
module pmu_event_unit_chk
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 40,
    parameter bit HAS_CYC = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq,
    input logic        glb_en,
    input logic [31:0] cnten,
    input logic [31:0] ovf,
    input logic [63:0] cyc_val
);
    localparam logic [31:0] MASK = slot_mask(NUM_CTR, HAS_CYC);
    localparam logic [31:0] CFGW = cfg_word(NUM_CTR, CTR_W, HAS_CYC);

    p_cfg_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_CFG) |-> (reg_rdata == CFGW));

    p_cyc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !reg_wr) |=> $stable(cyc_val));

    p_cnten_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CNTEN_SET)
        |=> ((cnten & $past(reg_wdata) & MASK) == ($past(reg_wdata) & MASK)));

    p_bank_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnten & ~MASK) == 32'd0) && ((ovf & ~MASK) == 32'd0));

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_OVF_CLR && !glb_en)
        |=> ((ovf & $past(reg_wdata)) == 32'd0));

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_INTEN_CLR && reg_wdata == 32'hFFFF_FFFF) |=> !irq);
endmodule

bind pmu_event_unit pmu_event_unit_chk #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .HAS_CYC(HAS_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .glb_en(glb_en), .cnten(cnten), .ovf(ovf), .cyc_val(cyc_val64)
);

// File: tb/sim_pmu_event_unit.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped every clock. rdata and irq
// are compared against the model on every cycle.
module sim_pmu_event_unit;
    localparam logic [31:0] MASK = 32'h8000_000F;
    localparam logic [63:0] CMAX = 64'h0000_00FF_FFFF_FFFF;
    localparam logic [31:0] CFGW = 32'h0000_6704;
    localparam logic [31:0] IDV  = 32'h0A5C_1001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_in = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    pmu_event_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] mcnt [32];
    logic [31:0] mtype [32];
    logic [31:0] mfilt [32];
    logic [31:0] mcf, mcnten, minten, movf;
    logic        men;
    logic [3:0]  evt_pat = '0;
    bit          rnd = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, reg_addr, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [11:0] a);
        int i;
        if (a[11:8] == 4'd0) begin
            i = int'(a[7:3]);
            if (!MASK[i]) return 32'd0;
            return a[2] ? mcnt[i][63:32] : mcnt[i][31:0];
        end
        if (a[11:7] == 5'b01000) begin
            i = int'(a[6:2]);
            if (i == 31) return mcf;
            return (i < 4) ? mtype[i] : 32'd0;
        end
        if (a[11:7] == 5'b10100) begin
            i = int'(a[6:2]);
            return (i < 4) ? mfilt[i] : 32'd0;
        end
        case (a)
            12'hC00, 12'hC20: return mcnten;
            12'hC40, 12'hC60: return minten;
            12'hC80, 12'hCC0: return movf;
            12'hE00:          return CFGW;
            12'hE04:          return {31'd0, men};
            12'hE08:          return IDV;
            default:          return 32'd0;
        endcase
    endfunction

    task automatic model_step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                              input logic [3:0] e);
        logic [63:0] ncnt [32];
        logic [31:0] hw;
        logic [31:0] s, c;
        bit inc, rst;
        hw = '0;
        for (int i = 0; i < 32; i++) begin
            ncnt[i] = mcnt[i];
            if (MASK[i]) begin
                if (i == 31) inc = men && mcnten[i];
                else inc = men && mcnten[i] && (mtype[i] < 4) && e[mtype[i][1:0]];
                rst = wr && a == 12'hE04 && (i == 31 ? d[2] : d[1]);
                if (rst) ncnt[i] = '0;
                else if (wr && a[11:8] == 0 && int'(a[7:3]) == i && !a[2])
                    ncnt[i] = {mcnt[i][63:32], d};
                else if (wr && a[11:8] == 0 && int'(a[7:3]) == i && a[2])
                    ncnt[i] = {d, mcnt[i][31:0]} & CMAX;
                else if (inc) begin
                    if (mcnt[i] == CMAX) begin ncnt[i] = '0; hw[i] = 1'b1; end
                    else ncnt[i] = mcnt[i] + 64'd1;
                end
            end
        end
        for (int i = 0; i < 32; i++) mcnt[i] = ncnt[i];
        s = (wr && a == 12'hC00) ? d : 32'd0; c = (wr && a == 12'hC20) ? d : 32'd0;
        mcnten = ((mcnten & ~c) | s) & MASK;
        s = (wr && a == 12'hC40) ? d : 32'd0; c = (wr && a == 12'hC60) ? d : 32'd0;
        minten = ((minten & ~c) | s) & MASK;
        s = (wr && a == 12'hCC0) ? d : 32'd0; c = (wr && a == 12'hC80) ? d : 32'd0;
        movf = ((movf & ~c) | s | hw) & MASK;
        if (wr && a[11:7] == 5'b01000) begin
            if (a[6:2] == 5'd31) mcf = d;
            else if (a[6:2] < 5'd4) mtype[a[6:2]] = d & 32'hFF;
        end
        if (wr && a[11:7] == 5'b10100 && a[6:2] < 5'd4) mfilt[a[6:2]] = d;
        if (wr && a == 12'hE04) men = d[0];
    endtask

    task automatic cyc(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
        if (rnd) evt_pat = lfsr[3:0];
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_in = evt_pat;
        #1;
        chk(tag, reg_rdata, mread(a));
        chk(tag, {31'd0, irq}, {31'd0, |(movf & minten)});
        model_step(wr, a, d, evt_pat);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wrt(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1'b0, a, 32'd0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin mcnt[i] = '0; mtype[i] = '0; mfilt[i] = '0; end
        mcf = '0; mcnten = '0; minten = '0; movf = '0; men = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        rd(12'h000, "R13"); rd(12'h004, "R13"); rd(12'h0F8, "R13"); rd(12'hC00, "R13");
        rd(12'hC40, "R13"); rd(12'hC80, "R13"); rd(12'hE04, "R13"); rd(12'h400, "R13");
        rd(12'hA00, "R13");
        // R1 configuration word, writes ignored; R2 identification
        rd(12'hE00, "R1"); wrt(12'hE00, 32'h0, "R1"); rd(12'hE00, "R1");
        rd(12'hE08, "R2");
        // R12 type and filter words
        wrt(12'h400, 32'h0, "R12"); wrt(12'h404, 32'h1, "R12"); wrt(12'h408, 32'h2, "R12");
        wrt(12'h40C, 32'h107, "R12"); wrt(12'hA00, 32'hDEADBEEF, "R12");
        wrt(12'hA04, 32'h12345678, "R12"); wrt(12'h47C, 32'h55AA, "R12");
        rd(12'h40C, "R12"); rd(12'hA00, "R12"); rd(12'hA04, "R12"); rd(12'h47C, "R12");
        // R5 set/clear banks
        wrt(12'hC00, 32'hFFFF_FFFF, "R5"); rd(12'hC00, "R5"); rd(12'hC20, "R5");
        wrt(12'hC20, 32'h0, "R5"); wrt(12'hC00, 32'h0, "R5"); rd(12'hC00, "R5");
        wrt(12'hC20, 32'h2, "R5"); rd(12'hC20, "R5");
        // R3 counting under random events, counter 1 disabled, counter 3 type out of range
        wrt(12'hE04, 32'h1, "R3");
        rnd = 1;
        for (int n = 0; n < 60; n++) rd(12'(8 * (n % 4)), "R3");
        // R4 cycle counter
        for (int n = 0; n < 6; n++) rd(12'h0F8, "R4");
        // R6 wide layout
        wrt(12'h00C, 32'hAB, "R6"); rd(12'h008, "R6"); rd(12'h00C, "R6");
        wrt(12'h0FC, 32'h12, "R6"); rd(12'h0F8, "R6"); rd(12'h0FC, "R6");
        // R11 write wins over increment
        rnd = 0; evt_pat = 4'b0001;
        wrt(12'h000, 32'h100, "R11"); rd(12'h000, "R11"); rd(12'h000, "R11");
        // R7 wrap and R9 interrupt
        wrt(12'hC40, 32'h1, "R9");
        wrt(12'h004, 32'hFF, "R7"); wrt(12'h000, 32'hFFFF_FFFD, "R7");
        for (int n = 0; n < 6; n++) rd(12'hC80, "R7");
        rd(12'h004, "R7");
        // R8 overflow clear/set
        evt_pat = 4'b0000;
        wrt(12'hC80, 32'h1, "R8"); rd(12'hC80, "R8");
        wrt(12'hCC0, 32'h4, "R8"); rd(12'hCC0, "R8");
        wrt(12'hC40, 32'h4, "R9"); rd(12'hC80, "R9");
        wrt(12'hCC0, 32'h0, "R8"); rd(12'hCC0, "R8");
        wrt(12'hC60, 32'hFFFF_FFFF, "R9"); rd(12'hC40, "R9");
        // R10 control reset bits
        evt_pat = 4'b0111;
        for (int n = 0; n < 5; n++) rd(12'h010, "R10");
        wrt(12'hE04, 32'h3, "R10"); rd(12'h000, "R10"); rd(12'h010, "R10"); rd(12'hE04, "R10");
        wrt(12'hE04, 32'h5, "R10"); rd(12'h0F8, "R10"); rd(12'h0FC, "R10");
        // R3 global disable freezes everything
        rnd = 1;
        wrt(12'hE04, 32'h0, "R3");
        for (int n = 0; n < 10; n++) rd(12'(8 * (n % 4)), "R3");
        rd(12'h0F8, "R3");
        // R4 cycle counter wrap sets overflow bit 31
        rnd = 0; evt_pat = 4'b0000;
        wrt(12'hE04, 32'h1, "R4"); wrt(12'h0FC, 32'hFF, "R4"); wrt(12'h0F8, 32'hFFFF_FFFC, "R4");
        for (int n = 0; n < 6; n++) rd(12'hC80, "R4");
        // soak with random events over several readbacks
        rnd = 1;
        for (int n = 0; n < 200; n++) rd(12'(8 * (n % 4) + 4 * (n % 2)), "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule